// File: doc/BRIEF.md
# Streaming Mask-and-Reorder Copy Engine

This block copies a stream of 32-byte words from an input port to an output port. On the way each word can be combined with a 256-bit mask word, and its bytes can be reordered. Software-side logic first loads the mask. It then issues a start with a 15-bit function word and a 32-bit byte count. The engine accepts exactly as many input words as the byte count needs, transforms each one, and presents it on the output with a byte-enable and a last flag.

The function word carries two codes that matter. The byte-order code sits in bits 1:0 and the mask-operation code in bits 4:2. The mask operation is applied first and the byte reordering second. Bits 6:5 form a reflect field that this engine treats as reserved. A start with an undefined code is refused: an error flag is raised and no words move. A completion pulse marks the end of every accepted operation.

Top module: `pt_xform_engine`

## Requirements
- R1: Synchronous active-low reset leaves the engine idle. After reset busy_o, done_o, err_o, out_valid_o and in_ready_o are all low.
- R2: The mask-operation code in func_i[4:2] selects the data transform. Code 0 passes the data unchanged. Code 1 gives data AND mask, code 2 gives data OR mask, code 3 gives data XOR mask, and code 4 replaces the data with the mask.
- R3: The byte-order code in func_i[1:0] selects the reordering. Byte i is bits 8i+7:8i. Code 0 leaves the bytes in place. Code 1 reverses the four bytes inside each 32-bit lane. Code 2 makes output byte i equal to input byte 31-i.
- R4: The mask operation acts on the input word, and the byte reordering acts on its result.
- R5: A start with a byte count L greater than zero transfers ceil(L/32) words. out_last_o is high only on the final word. Every other word carries out_be_o = all ones. On the final word, out_be_o bit i is high exactly when i < L - 32*(words before it). Bytes beyond the count are still transformed.
- R6: A start with mask code 5, 6 or 7, or with byte-order code 3, sets err_o in the next cycle and leaves the engine idle with no word accepted or produced. err_o stays high until the next start with legal codes, which clears it.
- R7: func_i bits 14:5, including the reflect field in bits 6:5, have no effect on the output or on any flag.
- R8: done_o is high for exactly one cycle. It rises in the cycle after the final output word is accepted. A legal start with a byte count of zero pulses done_o in the next cycle and moves no data.
- R9: While out_valid_o is high and out_ready_i is low, out_valid_o, out_data_o, out_be_o and out_last_o hold their values.
- R10: mask_load_i captures mask_data_i only while the engine is idle. A load while busy is ignored, and the words of the running operation keep using the earlier mask.
- R11: A start while busy is ignored. The running operation keeps its codes and its byte count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mask_load_i | input | 1 | Capture mask_data_i when idle |
| mask_data_i | input | 256 | Mask word |
| start_i | input | 1 | Begin an operation when idle |
| func_i | input | 15 | Function word: byte-order code 1:0, mask code 4:2, reserved above |
| len_i | input | 32 | Byte count of the operation |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Last start had an undefined code |
| in_valid_i | input | 1 | Input word valid |
| in_data_i | input | 256 | Input word |
| in_ready_o | output | 1 | Engine accepts the input word |
| out_valid_o | output | 1 | Output word valid |
| out_data_o | output | 256 | Transformed word |
| out_be_o | output | 32 | Byte enables of the output word |
| out_last_o | output | 1 | Final word of the operation |
| out_ready_i | input | 1 | Consumer accepts the output word |

## Verification
The bench builds the engine with its defaults: 32-byte words, a 15-bit function word and a 32-bit byte count. With these values the full-word reversal spans all 32 byte positions, and every tail length from 1 to 31 bytes maps onto a real byte-enable pattern. A behavioural model tracks busy, error, completion, the pending output word and the remaining byte count. It is compared with the ports on every cycle. The stimulus runs with the consumer both always ready and stalling every third cycle.

// File: rtl/pt_xform_pkg.sv
// Shared codes and widths for the streaming mask-and-reorder copy engine.
// Assumes a byte-addressed word with byte i at bits 8i+7:8i.
package pt_xform_pkg;

    // Bytes per lane for the lane-local reversal.
    localparam int LANE_BYTES = 4;

    // Position of the codes inside the function word.
    localparam int SW_LSB  = 0;
    localparam int SW_BITS = 2;
    localparam int BW_LSB  = 2;
    localparam int BW_BITS = 3;

    typedef enum logic [BW_BITS-1:0] {
        BW_PASS = 3'd0,
        BW_AND  = 3'd1,
        BW_OR   = 3'd2,
        BW_XOR  = 3'd3,
        BW_FILL = 3'd4
    } bw_op_e;

    typedef enum logic [SW_BITS-1:0] {
        SW_NONE   = 2'd0,
        SW_LANE   = 2'd1,
        SW_FULL   = 2'd2
    } sw_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } state_e;

endpackage

// File: rtl/pt_func_decode.sv
// Splits the low code bits of the function word into the mask-operation
// and byte-order codes, and flags codes with no defined meaning.
// Assumes only the low five bits of the function word carry meaning.
module pt_func_decode
    import pt_xform_pkg::*;
(
    input  logic [BW_LSB+BW_BITS-1:0] code_i,
    output logic [BW_BITS-1:0]        bw_op_o,
    output logic [SW_BITS-1:0]        sw_op_o,
    output logic                      illegal_o
);

    // Field extraction and legality check.
    always_comb begin
        bw_op_o   = code_i[BW_LSB +: BW_BITS];
        sw_op_o   = code_i[SW_LSB +: SW_BITS];
        illegal_o = (bw_op_o > BW_FILL) || (sw_op_o > SW_FULL);
    end

endmodule

// File: rtl/pt_bitwise_stage.sv
// Combines a data word with the mask word under the selected operation.
// Assumes the operation code was checked for legality beforehand.
module pt_bitwise_stage
    import pt_xform_pkg::*;
#(
    parameter int WORD_W = 256
) (
    input  logic [WORD_W-1:0]  data_i,
    input  logic [WORD_W-1:0]  mask_i,
    input  logic [BW_BITS-1:0] op_i,
    output logic [WORD_W-1:0]  data_o
);

    // Operation select.
    always_comb begin
        case (bw_op_e'(op_i))
            BW_AND:  data_o = data_i & mask_i;
            BW_OR:   data_o = data_i | mask_i;
            BW_XOR:  data_o = data_i ^ mask_i;
            BW_FILL: data_o = mask_i;
            default: data_o = data_i;
        endcase
    end

endmodule

// File: rtl/pt_swap_stage.sv
// Reorders the bytes of a word: none, reversal inside each lane, or
// reversal across the whole word. Assumes WORD_BYTES is a multiple of
// LANE_BYTES.
module pt_swap_stage
    import pt_xform_pkg::*;
#(
    parameter int WORD_BYTES = 32
) (
    input  logic [WORD_BYTES*8-1:0] data_i,
    input  logic [SW_BITS-1:0]      op_i,
    output logic [WORD_BYTES*8-1:0] data_o
);

    localparam int WORD_W = WORD_BYTES * 8;

    logic [WORD_W-1:0] lane_rev;
    logic [WORD_W-1:0] full_rev;

    for (genvar b = 0; b < WORD_BYTES; b++) begin : g_byte
        localparam int LANE = b / LANE_BYTES;
        localparam int POS  = b % LANE_BYTES;
        localparam int LSRC = LANE * LANE_BYTES + (LANE_BYTES - 1 - POS);
        localparam int FSRC = WORD_BYTES - 1 - b;
        assign lane_rev[b*8 +: 8] = data_i[LSRC*8 +: 8];
        assign full_rev[b*8 +: 8] = data_i[FSRC*8 +: 8];
    end

    // Permutation select.
    always_comb begin
        case (sw_op_e'(op_i))
            SW_LANE: data_o = lane_rev;
            SW_FULL: data_o = full_rev;
            default: data_o = data_i;
        endcase
    end

endmodule

// File: rtl/pt_len_tracker.sv
// Counts the bytes still to be accepted on the input side and derives
// the last-word flag and byte enables of the word being accepted.
// Assumes load and step are never high in the same cycle.
module pt_len_tracker #(
    parameter int WORD_BYTES = 32,
    parameter int LEN_W      = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load_i,
    input  logic [LEN_W-1:0]      len_i,
    input  logic                  step_i,
    output logic                  more_o,
    output logic                  last_o,
    output logic [WORD_BYTES-1:0] be_o
);

    localparam logic [LEN_W-1:0] STEP = LEN_W'(WORD_BYTES);

    logic [LEN_W-1:0] left_q;

    // Remaining byte count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (load_i) begin
            left_q <= len_i;
        end else if (step_i) begin
            left_q <= (left_q > STEP) ? (left_q - STEP) : '0;
        end
    end

    assign more_o = (left_q != '0);
    assign last_o = (left_q <= STEP);

    for (genvar b = 0; b < WORD_BYTES; b++) begin : g_be
        assign be_o[b] = (left_q > LEN_W'(b));
    end

endmodule

// File: rtl/pt_xform_engine.sv
// Streaming copy engine: each accepted input word is combined with the
// mask, byte-reordered and registered onto the output with byte enables.
// Assumes the mask is loaded before start; one output register stage.
module pt_xform_engine
    import pt_xform_pkg::*;
#(
    parameter int WORD_BYTES = 32,
    parameter int FUNC_W     = 15,
    parameter int LEN_W      = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    mask_load_i,
    input  logic [WORD_BYTES*8-1:0] mask_data_i,
    input  logic                    start_i,
    input  logic [FUNC_W-1:0]       func_i,
    input  logic [LEN_W-1:0]        len_i,
    output logic                    busy_o,
    output logic                    done_o,
    output logic                    err_o,
    input  logic                    in_valid_i,
    input  logic [WORD_BYTES*8-1:0] in_data_i,
    output logic                    in_ready_o,
    output logic                    out_valid_o,
    output logic [WORD_BYTES*8-1:0] out_data_o,
    output logic [WORD_BYTES-1:0]   out_be_o,
    output logic                    out_last_o,
    input  logic                    out_ready_i
);

    localparam int WORD_W = WORD_BYTES * 8;
    localparam int CODE_W = BW_LSB + BW_BITS;

    state_e              state_q;
    logic [WORD_W-1:0]   mask_q;
    logic [BW_BITS-1:0]  bw_q;
    logic [SW_BITS-1:0]  sw_q;
    logic                err_q;
    logic                done_q;
    logic                ov_q;
    logic [WORD_W-1:0]   od_q;
    logic [WORD_BYTES-1:0] obe_q;
    logic                olast_q;

    logic [BW_BITS-1:0]  dec_bw;
    logic [SW_BITS-1:0]  dec_sw;
    logic                dec_bad;
    logic                more;
    logic                trk_last;
    logic [WORD_BYTES-1:0] trk_be;
    logic [WORD_W-1:0]   masked;
    logic [WORD_W-1:0]   swapped;

    logic start_ok;
    logic go;
    logic in_fire;
    logic out_fire;

    pt_func_decode u_dec (
        .code_i    (func_i[CODE_W-1:0]),
        .bw_op_o   (dec_bw),
        .sw_op_o   (dec_sw),
        .illegal_o (dec_bad)
    );

    assign start_ok = start_i && (state_q == ST_IDLE);
    assign go       = start_ok && !dec_bad && (len_i != '0);
    assign in_ready_o = (state_q == ST_RUN) && more && (!ov_q || out_ready_i);
    assign in_fire  = in_valid_i && in_ready_o;
    assign out_fire = ov_q && out_ready_i;

    pt_len_tracker #(
        .WORD_BYTES (WORD_BYTES),
        .LEN_W      (LEN_W)
    ) u_len (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (go),
        .len_i  (len_i),
        .step_i (in_fire),
        .more_o (more),
        .last_o (trk_last),
        .be_o   (trk_be)
    );

    pt_bitwise_stage #(
        .WORD_W (WORD_W)
    ) u_bw (
        .data_i (in_data_i),
        .mask_i (mask_q),
        .op_i   (bw_q),
        .data_o (masked)
    );

    pt_swap_stage #(
        .WORD_BYTES (WORD_BYTES)
    ) u_sw (
        .data_i (masked),
        .op_i   (sw_q),
        .data_o (swapped)
    );

    // Operation state: idle until a legal nonzero start, run until the last word leaves.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else if (go) begin
            state_q <= ST_RUN;
        end else if (out_fire && olast_q) begin
            state_q <= ST_IDLE;
        end
    end

    // Latch the codes of an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bw_q <= '0;
            sw_q <= '0;
        end else if (go) begin
            bw_q <= dec_bw;
            sw_q <= dec_sw;
        end
    end

    // Mask register, writable only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (mask_load_i && (state_q == ST_IDLE)) begin
            mask_q <= mask_data_i;
        end
    end

    // Error flag follows the legality of the latest accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (start_ok) begin
            err_q <= dec_bad;
        end
    end

    // Completion pulse after the last output word or an empty legal start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else begin
            done_q <= (out_fire && olast_q) || (start_ok && !dec_bad && (len_i == '0));
        end
    end

    // Output register: valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ov_q <= 1'b0;
        end else if (in_fire) begin
            ov_q <= 1'b1;
        end else if (out_fire) begin
            ov_q <= 1'b0;
        end
    end

    // Output register: payload, enables and last flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            od_q    <= '0;
            obe_q   <= '0;
            olast_q <= 1'b0;
        end else if (in_fire) begin
            od_q    <= swapped;
            obe_q   <= trk_last ? trk_be : '1;
            olast_q <= trk_last;
        end
    end

    assign busy_o      = (state_q == ST_RUN);
    assign done_o      = done_q;
    assign err_o       = err_q;
    assign out_valid_o = ov_q;
    assign out_data_o  = od_q;
    assign out_be_o    = obe_q;
    assign out_last_o  = olast_q;

endmodule

// File: rtl/pt_xform_checker.sv
// Protocol and flag properties of the copy engine, attached by bind.
// Assumes the default function word layout (codes in bits 4:0).
module pt_xform_checker #(
    parameter int WORD_BYTES = 32,
    parameter int FUNC_W     = 15,
    parameter int LEN_W      = 32
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    start_i,
    input logic [FUNC_W-1:0]       func_i,
    input logic [LEN_W-1:0]        len_i,
    input logic                    busy_o,
    input logic                    done_o,
    input logic                    err_o,
    input logic                    in_ready_o,
    input logic                    out_valid_o,
    input logic [WORD_BYTES*8-1:0] out_data_o,
    input logic [WORD_BYTES-1:0]   out_be_o,
    input logic                    out_last_o,
    input logic                    out_ready_i
);

    logic bad_code;
    assign bad_code = (func_i[4:2] > 3'd4) || (func_i[1:0] == 2'd3);

    // R9
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o)
            && $stable(out_be_o) && $stable(out_last_o));

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o && !out_valid_o);

    // R6
    bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && !busy_o && bad_code |=> err_o && !busy_o && !out_valid_o);

    // R7
    rsvd_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && !busy_o && !bad_code && (|func_i[FUNC_W-1:5]) && (len_i != '0)
            |=> busy_o && !err_o);

    // R11
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && start_i && !(out_valid_o && out_ready_i && out_last_o) |=> busy_o);

    // R5
    ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready_o |-> busy_o);

endmodule

bind pt_xform_engine pt_xform_checker #(
    .WORD_BYTES (WORD_BYTES),
    .FUNC_W     (FUNC_W),
    .LEN_W      (LEN_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .func_i      (func_i),
    .len_i       (len_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .err_o       (err_o),
    .in_ready_o  (in_ready_o),
    .out_valid_o (out_valid_o),
    .out_data_o  (out_data_o),
    .out_be_o    (out_be_o),
    .out_last_o  (out_last_o),
    .out_ready_i (out_ready_i)
);

// File: tb/pt_xform_engine_tb_top.sv
// Bench for the copy engine: a behavioural model compared every cycle.
module pt_xform_engine_tb_top;

    localparam int WB = 32;
    localparam int WW = WB * 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mask_load_i = 1'b0;
    logic [WW-1:0] mask_data_i = '0;
    logic          start_i = 1'b0;
    logic [14:0]   func_i = '0;
    logic [31:0]   len_i = '0;
    logic          busy_o, done_o, err_o;
    logic          in_valid_i = 1'b0;
    logic [WW-1:0] in_data_i = '0;
    logic          in_ready_o;
    logic          out_valid_o;
    logic [WW-1:0] out_data_o;
    logic [WB-1:0] out_be_o;
    logic          out_last_o;
    logic          out_ready_i = 1'b1;

    always #2 clk = ~clk;

    pt_xform_engine dut_i (
        .clk(clk), .rst_n(rst_n), .mask_load_i(mask_load_i), .mask_data_i(mask_data_i),
        .start_i(start_i), .func_i(func_i), .len_i(len_i), .busy_o(busy_o),
        .done_o(done_o), .err_o(err_o), .in_valid_i(in_valid_i), .in_data_i(in_data_i),
        .in_ready_o(in_ready_o), .out_valid_o(out_valid_o), .out_data_o(out_data_o),
        .out_be_o(out_be_o), .out_last_o(out_last_o), .out_ready_i(out_ready_i)
    );

    int    checks = 0;
    int    bad = 0;
    string tag = "R1";
    bit    model_on = 1'b0;
    bit    stall_en = 1'b0;
    int    cyc = 0;

    // Model state
    logic [WW-1:0] m_mask = '0;
    bit            m_busy = 1'b0;
    bit            m_err = 1'b0;
    bit            m_done = 1'b0;
    longint        m_left = 0;
    int            m_bw = 0;
    int            m_sw = 0;
    logic [WW-1:0] q_data[$];
    logic [WB-1:0] q_be[$];
    bit            q_last[$];

    task automatic chk(bit ok, string what, logic [WW-1:0] act, logic [WW-1:0] exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [WW-1:0] ref_xf(logic [WW-1:0] d, logic [WW-1:0] m, int bw, int sw);
        logic [WW-1:0] t;
        logic [WW-1:0] r;
        case (bw)
            0: t = d;
            1: t = d & m;
            2: t = d | m;
            3: t = d ^ m;
            default: t = m;
        endcase
        for (int i = 0; i < WB; i++) begin
            int src;
            if (sw == 1) src = (i / 4) * 4 + 3 - (i % 4);
            else if (sw == 2) src = WB - 1 - i;
            else src = i;
            r[i*8 +: 8] = t[src*8 +: 8];
        end
        return r;
    endfunction

    function automatic logic [14:0] mkf(int bw, int sw, int refl, int rsv);
        return {8'(rsv), 2'(refl), 3'(bw), 2'(sw)};
    endfunction

    // Per-cycle comparison and model advance.
    always @(negedge clk) begin : mon
        bit exp_ready;
        bit ofire;
        bit ifire;
        bit was_busy;
        bit legal;
        logic [WB-1:0] be;
        if (model_on) begin
            chk(busy_o === m_busy, "busy", WW'(busy_o), WW'(m_busy));
            chk(err_o === m_err, "err", WW'(err_o), WW'(m_err));
            chk(done_o === m_done, "done", WW'(done_o), WW'(m_done));
            chk(out_valid_o === (q_data.size() != 0), "out_valid", WW'(out_valid_o), WW'(q_data.size() != 0));
            exp_ready = m_busy && (m_left > 0) && (q_data.size() == 0 || out_ready_i);
            chk(in_ready_o === exp_ready, "in_ready", WW'(in_ready_o), WW'(exp_ready));
            if (q_data.size() != 0) begin
                chk(out_data_o === q_data[0], "data", out_data_o, q_data[0]);
                chk(out_be_o === q_be[0], "byte_enable", WW'(out_be_o), WW'(q_be[0]));
                chk(out_last_o === q_last[0], "last", WW'(out_last_o), WW'(q_last[0]));
            end
            was_busy = m_busy;
            ofire = (q_data.size() != 0) && out_ready_i;
            ifire = exp_ready && in_valid_i;
            m_done = 1'b0;
            if (ofire) begin
                if (q_last[0]) begin
                    m_busy = 1'b0;
                    m_done = 1'b1;
                end
                void'(q_data.pop_front());
                void'(q_be.pop_front());
                void'(q_last.pop_front());
            end
            if (ifire) begin
                for (int i = 0; i < WB; i++) be[i] = (i < m_left);
                q_data.push_back(ref_xf(in_data_i, m_mask, m_bw, m_sw));
                q_be.push_back(be);
                q_last.push_back(m_left <= WB);
                m_left = (m_left > WB) ? m_left - WB : 0;
            end
            if (start_i && !was_busy) begin
                legal = (func_i[4:2] <= 3'd4) && (func_i[1:0] != 2'd3);
                if (!legal) begin
                    m_err = 1'b1;
                end else begin
                    m_err = 1'b0;
                    if (len_i == 0) begin
                        m_done = 1'b1;
                    end else begin
                        m_busy = 1'b1;
                        m_left = len_i;
                        m_bw = int'(func_i[4:2]);
                        m_sw = int'(func_i[1:0]);
                    end
                end
            end
            if (mask_load_i && !was_busy) m_mask = mask_data_i;
        end
    end

    // Consumer readiness pattern.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        #1 out_ready_i = !stall_en || (cyc % 3 != 0);
    end

    // Watchdog.
    always @(posedge clk) begin
        if (cyc > 100000) begin
            checks++;
            bad++;
            $display("FAIL watchdog actual=%0d expected<=100000", cyc);
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic load_mask(logic [WW-1:0] m);
        mask_load_i = 1'b1;
        mask_data_i = m;
        tick();
        mask_load_i = 1'b0;
    endtask

    task automatic start_op(logic [14:0] f, logic [31:0] l);
        start_i = 1'b1;
        func_i = f;
        len_i = l;
        tick();
        start_i = 1'b0;
    endtask

    task automatic send_words(int n);
        for (int k = 0; k < n; k++) begin
            bit acc;
            in_valid_i = 1'b1;
            in_data_i = {$urandom, $urandom, $urandom, $urandom,
                         $urandom, $urandom, $urandom, $urandom};
            do begin
                @(negedge clk);
                acc = in_ready_o;
                tick();
            end while (!acc);
        end
        in_valid_i = 1'b0;
    endtask

    task automatic drain();
        for (int k = 0; k < 500; k++) begin
            if (!m_busy && q_data.size() == 0) break;
            tick();
        end
        repeat (2) tick();
    endtask

    task automatic run(int bw, int sw, int refl, int rsv, int len);
        start_op(mkf(bw, sw, refl, rsv), len);
        send_words((len + WB - 1) / WB);
        drain();
    endtask

    initial begin
        repeat (3) tick();
        @(negedge clk);
        tag = "R1";
        chk(!busy_o && !done_o && !err_o && !out_valid_o && !in_ready_o, "reset state",
            WW'({busy_o, done_o, err_o, out_valid_o, in_ready_o}), '0);
        @(posedge clk);
        #1 rst_n = 1'b1;
        model_on = 1'b1;
        tick();

        tag = "R2/R3/R4/R5";
        load_mask({8{32'hF0F0_33CC}});
        run(0, 0, 0, 0, 64);
        stall_en = 1'b1;
        run(1, 1, 0, 0, 96);
        stall_en = 1'b0;
        run(2, 2, 0, 0, 40);
        run(3, 0, 0, 0, 33);
        load_mask({$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom});
        run(4, 2, 0, 0, 32);
        stall_en = 1'b1;
        tag = "R4/R5/R9";
        run(3, 1, 0, 0, 100);
        run(1, 2, 0, 0, 63);
        stall_en = 1'b0;

        tag = "R6";
        start_op(mkf(5, 0, 0, 0), 64);
        in_valid_i = 1'b1;
        repeat (4) tick();
        in_valid_i = 1'b0;
        @(negedge clk);
        chk(err_o === 1'b1 && !busy_o, "err after mask code 5", WW'({err_o, busy_o}), WW'(2'b10));
        tick();
        start_op(mkf(7, 1, 0, 0), 32);
        repeat (2) tick();
        start_op(mkf(1, 3, 0, 0), 32);
        in_valid_i = 1'b1;
        repeat (3) tick();
        in_valid_i = 1'b0;
        @(negedge clk);
        chk(err_o === 1'b1 && !out_valid_o, "err after order code 3", WW'({err_o, out_valid_o}), WW'(2'b10));
        tick();
        run(2, 1, 0, 0, 32);
        @(negedge clk);
        chk(err_o === 1'b0, "err cleared by legal start", WW'(err_o), '0);
        tick();

        tag = "R7";
        run(1, 2, 3, 8'hA5, 64);
        run(3, 1, 2, 8'hFF, 17);

        tag = "R8";
        start_op(mkf(3, 2, 0, 0), 0);
        repeat (3) tick();
        run(0, 1, 0, 0, 1);

        tag = "R10";
        start_op(mkf(3, 0, 0, 0), 96);
        send_words(1);
        load_mask('1);
        send_words(2);
        drain();

        tag = "R11";
        stall_en = 1'b1;
        start_op(mkf(2, 2, 0, 0), 80);
        send_words(1);
        start_op(mkf(4, 0, 0, 0), 320);
        send_words(2);
        drain();
        stall_en = 1'b0;
        repeat (4) tick();

        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule